// File: doc/BRIEF.md
# Interleaved Memory Decoder Target Lookup

This block is one address decoder for an interleaved memory region. Software loads three 32-bit registers through a small write port. The control word holds a commit flag, a granularity code and a way-count code. The two target words hold up to eight 8-bit downstream port numbers.

A lookup presents a host physical address. The address is split into interleave slices whose size comes from the granularity code. The slice index, reduced modulo the number of ways, selects one stored port number. One cycle later the block returns a found flag and that port number. A decoder that is not committed, or that has a way-count code outside the supported range, reports no target.

Top module: `ilv_target_decoder`

## Requirements
- R1: After reset all three registers are zero, `rsp_valid`, `rsp_hit` and `rsp_port` are 0, and a lookup made before any write reports no target.
- R2: A lookup presented with `lk_valid` high at a clock edge produces `rsp_valid` high at the next edge, and `rsp_valid` is low in every cycle that does not follow a lookup. Back-to-back lookups give back-to-back responses in order.
- R3: Control bit 8 is the commit flag. While it is 0, every lookup returns `rsp_hit` = 0.
- R4: Control bits [7:4] hold the way-count code w, giving 2^w ways. Codes 0 to 3 are valid; any code from 4 to 15 makes every lookup return `rsp_hit` = 0.
- R5: Control bits [3:0] hold the granularity code g, giving slices of 256 << g bytes. The way index is (address / (256 << g)) mod 2^w, which is address bits [8+g +: w]. Address bits below bit 8+g have no effect on the result.
- R6: Way indices 0 to 3 return byte k of the low target word, that is bits [8k+7:8k] for k equal to the index.
- R7: Way indices 4 to 7 return byte k of the high target word, that is bits [8k+7:8k] for k equal to the index minus 4.
- R8: A write with `cfg_we` high loads `cfg_wdata` into the control word when `cfg_sel` is 0, into the low target word when it is 1, and into the high target word when it is 2. A write with `cfg_sel` equal to 3 changes nothing. A lookup in the same cycle as a write uses the register contents from before that write.
- R9: Whenever a response reports no target, `rsp_port` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 low targets, 2 high targets |
| cfg_wdata | input | 32 | Register write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Host physical address to decode |
| rsp_valid | output | 1 | Response present, one cycle after a request |
| rsp_hit | output | 1 | A target was found |
| rsp_port | output | 8 | Downstream port number, 0 on a miss |

## Verification
The bench sets a different port number in every byte slot. It then walks all eight way indices, so that a wrong byte lane or a mix-up between the low and high words returns a visibly wrong port. It changes the granularity and sets address bits just below and just above the slice boundary, which catches a decoder that shifts from the wrong bit or ignores the granularity. Way-count codes 0 and 4 and an uncommitted decoder are each tried. Here a design that masked or gated wrongly would report a hit. A write to the unused select value, and back-to-back lookups, expose a design that corrupts a register or drops or reorders responses.

// File: rtl/ilv_target_decoder.sv
module ilv_target_decoder #(
  parameter int ADDR_W = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [7:0]        rsp_port
);

  logic [31:0] ctrl_q, tgt_lo_q, tgt_hi_q;

  // R8: register writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      tgt_lo_q <= '0;
      tgt_hi_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0:    ctrl_q   <= cfg_wdata;
        2'd1:    tgt_lo_q <= cfg_wdata;
        2'd2:    tgt_hi_q <= cfg_wdata;
        default: ;
      endcase
    end
  end

  logic [3:0] gran, ways;
  logic       committed, ways_ok;
  assign gran      = ctrl_q[3:0];
  assign ways      = ctrl_q[7:4];
  assign committed = ctrl_q[8];
  assign ways_ok   = (ways <= 4'd3);             // R4

  // R5: slice index from bit 8+g upward
  logic [ADDR_W-1:0] sliced;
  logic [2:0]        way_mask, way_idx;
  assign sliced = lk_addr >> ({1'b0, gran} + 5'd8);

  always_comb begin
    case (ways[1:0])
      2'd0:    way_mask = 3'b000;
      2'd1:    way_mask = 3'b001;
      2'd2:    way_mask = 3'b011;
      default: way_mask = 3'b111;
    endcase
  end
  assign way_idx = sliced[2:0] & way_mask;

  // R6, R7: byte pick from the two target words
  logic [31:0] tgt_word;
  logic [7:0]  sel_port;
  assign tgt_word = way_idx[2] ? tgt_hi_q : tgt_lo_q;
  assign sel_port = tgt_word[{way_idx[1:0], 3'b000} +: 8];

  logic hit_d;
  assign hit_d = committed && ways_ok;           // R3, R4

  // R2, R9: registered response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_port  <= 8'd0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && hit_d;
      rsp_port  <= (lk_valid && hit_d) ? sel_port : 8'd0;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{ctrl_q[31:9], sliced[ADDR_W-1:3]};

endmodule

// File: rtl/ilv_target_decoder_chk.sv
module ilv_target_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_valid,
  input logic [31:0] ctrl,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic [7:0]  rsp_port
);

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid); // R2

  AST_HIT_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid); // R2

  AST_UNCOMMITTED_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !ctrl[8]) |=> !rsp_hit); // R3

  AST_BAD_WAYS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && (ctrl[7:4] > 4'd3)) |=> !rsp_hit); // R4

  AST_MISS_PORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_port == 8'd0)); // R9

endmodule

bind ilv_target_decoder ilv_target_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .ctrl(ctrl_q),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_port(rsp_port)
);

// File: tb/ilv_target_decoder_test.sv
module ilv_target_decoder_test;
  localparam int ADDR_W = 52;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_sel = 2'd0;
  logic [31:0]       cfg_wdata = '0;
  logic              lk_valid = 1'b0;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic              rsp_valid, rsp_hit;
  logic [7:0]        rsp_port;

  int checks = 0;
  int errors = 0;
  bit [8:0] exp_q[$];
  string    tag_q[$];
  logic [31:0] m_ctrl = '0, m_lo = '0, m_hi = '0;

  always #10 clk = ~clk;

  ilv_target_decoder #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_port(rsp_port)
  );

  function automatic bit [8:0] model(input logic [ADDR_W-1:0] a);
    longint unsigned g, w, idx;
    g = longint'(m_ctrl[3:0]);
    w = longint'(m_ctrl[7:4]);
    if (!m_ctrl[8] || w > 3) return 9'd0;
    idx = (longint'(a) / (longint'(256) << g)) % (longint'(1) << w);
    if (idx < 4) return {1'b1, m_lo[idx*8 +: 8]};
    return {1'b1, m_hi[(idx-4)*8 +: 8]};
  endfunction

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 2'd0) m_ctrl = d;
    else if (sel == 2'd1) m_lo = d;
    else if (sel == 2'd2) m_hi = d;
  endtask

  // drives a lookup for one cycle and leaves lk_valid high; call idle() to end
  task automatic lookup(input logic [ADDR_W-1:0] a, input string tag);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    exp_q.push_back(model(a));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    lk_valid = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compare every response with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R2: response with no lookup pending, actual hit=%0b port=%02h expected none",
                   rsp_hit, rsp_port);
        end else begin
          bit [8:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({rsp_hit, rsp_port} !== e) begin
            errors++;
            $display("FAIL %s: actual hit=%0b port=%02h expected hit=%0b port=%02h",
                     t, rsp_hit, rsp_port, e[8], e[7:0]);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({rsp_valid, rsp_hit, rsp_port} !== 10'd0) begin
      errors++;
      $display("FAIL R1: outputs in reset actual %03h expected 000", {rsp_valid, rsp_hit, rsp_port});
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2: idle rsp_valid actual %0b expected 0", rsp_valid);
    end

    lookup(52'h0, "R1"); lookup(52'h700, "R1"); idle();

    cfg_write(2'd1, 32'h44332211);
    cfg_write(2'd2, 32'h88776655);
    cfg_write(2'd0, 32'h0000_0030);                // 8 ways, not committed
    lookup(52'h300, "R3"); lookup(52'h500, "R3"); idle();

    cfg_write(2'd0, 32'h0000_0130);                // commit, 8 ways, 256 B
    for (int i = 0; i < 4; i++) lookup(52'(i) << 8, "R6");
    for (int i = 4; i < 8; i++) lookup(52'(i) << 8, "R7");
    idle();
    lookup(52'h1234_5FF, "R5"); lookup(52'hABC_DE0_0000, "R5"); idle();

    cfg_write(2'd0, 32'h0000_0122);                // 4 ways, 1 KiB
    lookup(52'h0C00, "R5"); lookup(52'h0300, "R5");
    lookup(52'h1BFF, "R5"); lookup(52'h0800, "R5"); idle();

    cfg_write(2'd0, 32'h0000_0105);                // 1 way, 8 KiB
    lookup(52'hF_FFFF, "R5"); idle();

    cfg_write(2'd0, 32'h0000_0140);                // way code 4 invalid
    lookup(52'h300, "R4"); idle();
    cfg_write(2'd0, 32'h0000_01F0);                // way code 15 invalid
    lookup(52'h500, "R4"); idle();

    cfg_write(2'd0, 32'h0000_0130);
    cfg_write(2'd3, 32'h0000_0000);                // ignored select
    lookup(52'h000, "R8"); lookup(52'h700, "R8"); idle();
    cfg_write(2'd2, 32'hDEADBEEF);
    lookup(52'h600, "R8"); lookup(52'h100, "R8"); idle();

    // lookup in the same cycle as a write sees the old value
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 32'hCAFE_F00D;
    lk_valid = 1'b1; lk_addr = 52'h000;
    exp_q.push_back(model(52'h000));
    tag_q.push_back("R8");
    @(negedge clk);
    cfg_we = 1'b0; lk_valid = 1'b0;
    m_lo = 32'hCAFE_F00D;
    @(negedge clk);
    lookup(52'h000, "R8"); lookup(52'h300, "R9"); idle();

    cfg_write(2'd0, 32'h0000_0030);
    lookup(52'h200, "R9"); idle();

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: responses missing actual %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule